// File: doc/BRIEF.md
# Legacy INTx Pulse Interrupt Collector

This block gathers the four legacy INTx assertion events of a PCIe root port (INTA, INTB, INTC, INTD), each delivered as a single-cycle pulse, into sticky status bits. Software clears those bits by writing ones to them. A pulse enable register gates the status bits, and the gated result is reduced to one registered interrupt line that goes to the system interrupt controller.

Access is through a plain 32-bit register port with a word address. In each register, line i occupies bit 2·i, so INTA through INTD land on bits 0, 2, 4 and 6. The normal service sequence reads the pulse status word and writes the same value back. That clears exactly the events that were seen and keeps any that arrived in between.

Two more interrupt groups, level and special, get a status word and an enable word each. They use the same bit layout but are plain read/write storage: they do not drive the interrupt line.

Top module: `intx_pulse_collector`

## Requirements
- R1: After synchronous reset, every register reads zero, `irq` is low and `reg_rd_data` is zero.
- R2: A pulse on `intx_pulse[i]` sampled at a clock edge sets status bit 2·i of the pulse status word (word 0, byte offset 0x000).
- R3: A pulse status bit stays set after its input returns low, until a clearing write removes it.
- R4: A write to word 0 clears each pulse status bit whose data bit is 1 and leaves the bits written 0 unchanged.
- R5: When a pulse and a clearing write target the same status bit in the same cycle, the bit ends that cycle set.
- R6: The pulse enable word is word 3 (offset 0x00C) and bit 2·i enables line i. `irq` is registered and equals, one cycle later, the OR over all lines of pulse status AND pulse enable.
- R7: Words 1, 2, 4 and 5 (offsets 0x004 level status, 0x008 special status, 0x010 level enable, 0x014 special enable) store bits 0, 2, 4 and 6 as written. They affect neither `irq` nor the pulse status.
- R8: Odd bit positions and bits above bit 6 always read zero in every word. Writes to them have no effect.
- R9: Words 6 and 7 (offsets 0x018 and 0x01C) read zero, and writes to them change no register.
- R10: `reg_rd_data` is registered: after a clock edge it shows the word addressed at that edge, with the contents the word held just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| intx_pulse | input | NUM_LINES | One-cycle assertion events, bit i for line i (INTA..INTD) |
| reg_wr_en | input | 1 | Write strobe for the register port |
| reg_word_addr | input | 3 | Word index of the register accessed (byte offset / 4) |
| reg_wr_data | input | DATA_W | Write data |
| reg_rd_data | output | DATA_W | Registered read data |
| irq | output | 1 | Combined, registered pulse interrupt |

## Verification
A lost or stuck status bit shows up in the next read of word 0, one cycle after the edge that should have changed it. `irq` follows the same fault one cycle later, so an exhaustive sweep over pulse patterns and enable patterns exposes any wrong gating within two cycles of the pulse. A clear that is applied with the wrong priority, to the wrong lane or to the wrong word shows up as a status or storage word that differs on the very next read. For that reason, every write in the bench is followed by a read-back of all affected words.

// File: rtl/intx_pkg.sv
package intx_pkg;
  // Word index width of the register port (eight word slots).
  localparam int WORD_IDX_W = 3;

  // Word indices; pulse status must stay at 0 (service software relies on it).
  localparam int IDX_PLS_ST = 0;
  localparam int IDX_LVL_ST = 1;
  localparam int IDX_SPC_ST = 2;
  localparam int IDX_PLS_EN = 3;
  localparam int IDX_LVL_EN = 4;
  localparam int IDX_SPC_EN = 5;

  // Plain storage words occupy indices 1..NUM_STORE.
  localparam int NUM_STORE = 5;
endpackage

// File: rtl/intx_sticky_bank.sv
module intx_sticky_bank #(
  parameter int NUM_LINES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] set_pulse,
  input  logic                 clr_en,
  input  logic [NUM_LINES-1:0] clr_mask,
  output logic [NUM_LINES-1:0] status_q
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        status_q[g] <= 1'b0;
      else if (set_pulse[g])
        status_q[g] <= 1'b1;             // a new event beats a clear
      else if (clr_en && clr_mask[g])
        status_q[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/intx_store_reg.sv
module intx_store_reg #(
  parameter int NUM_LINES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [NUM_LINES-1:0] wr_lines,
  output logic [NUM_LINES-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (wr_en)
      q <= wr_lines;
  end
endmodule

// File: rtl/intx_pulse_collector.sv
module intx_pulse_collector
  import intx_pkg::*;
#(
  parameter int NUM_LINES   = 4,
  parameter int LINE_STRIDE = 2,
  parameter int DATA_W      = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_LINES-1:0]  intx_pulse,
  input  logic                  reg_wr_en,
  input  logic [WORD_IDX_W-1:0] reg_word_addr,
  input  logic [DATA_W-1:0]     reg_wr_data,
  output logic [DATA_W-1:0]     reg_rd_data,
  output logic                  irq
);
  logic [NUM_LINES-1:0] wr_lines;
  logic [NUM_LINES-1:0] status_q;
  logic [NUM_LINES-1:0] pls_en;
  logic [NUM_LINES-1:0] rd_lines;
  logic [NUM_LINES-1:0] store_q [NUM_STORE];
  logic [DATA_W-1:0]    rd_word;
  logic [DATA_W-1:0]    lane_bits;
  logic                 clr_en;
  logic                 unused_wr_bits;

  // Gather line bits from the write word (line i at bit i*LINE_STRIDE).
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_gather
    assign wr_lines[g] = reg_wr_data[g*LINE_STRIDE];
  end

  // Spread line bits back into a word; every other position reads zero.
  for (genvar b = 0; b < DATA_W; b++) begin : g_spread
    if ((b % LINE_STRIDE) == 0 && (b / LINE_STRIDE) < NUM_LINES) begin : g_lane
      assign rd_word[b]   = rd_lines[b/LINE_STRIDE];
      assign lane_bits[b] = 1'b1;
    end else begin : g_pad
      assign rd_word[b]   = 1'b0;
      assign lane_bits[b] = 1'b0;
    end
  end

  assign unused_wr_bits = ^(reg_wr_data & ~lane_bits);

  assign clr_en = reg_wr_en && (reg_word_addr == WORD_IDX_W'(IDX_PLS_ST));

  intx_sticky_bank #(.NUM_LINES(NUM_LINES)) u_sticky (
    .clk      (clk),
    .rst      (rst),
    .set_pulse(intx_pulse),
    .clr_en   (clr_en),
    .clr_mask (wr_lines),
    .status_q (status_q)
  );

  for (genvar s = 0; s < NUM_STORE; s++) begin : g_store
    intx_store_reg #(.NUM_LINES(NUM_LINES)) u_store (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (reg_wr_en && (reg_word_addr == WORD_IDX_W'(s + 1))),
      .wr_lines(wr_lines),
      .q       (store_q[s])
    );
  end

  assign pls_en = store_q[IDX_PLS_EN-1];

  always_comb begin
    rd_lines = '0;
    if (reg_word_addr == WORD_IDX_W'(IDX_PLS_ST))
      rd_lines = status_q;
    for (int s = 0; s < NUM_STORE; s++) begin
      if (reg_word_addr == WORD_IDX_W'(s + 1))
        rd_lines = store_q[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_data <= '0;
      irq         <= 1'b0;
    end else begin
      reg_rd_data <= rd_word;
      irq         <= |(status_q & pls_en);
    end
  end
endmodule

// File: rtl/intx_pulse_collector_chk.sv
module intx_pulse_collector_chk
  import intx_pkg::*;
#(
  parameter int NUM_LINES   = 4,
  parameter int LINE_STRIDE = 2,
  parameter int DATA_W      = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_LINES-1:0]  intx_pulse,
  input logic                  reg_wr_en,
  input logic [WORD_IDX_W-1:0] reg_word_addr,
  input logic [DATA_W-1:0]     reg_wr_data,
  input logic [DATA_W-1:0]     reg_rd_data,
  input logic                  irq,
  input logic [NUM_LINES-1:0]  status_q,
  input logic [NUM_LINES-1:0]  pls_en
);
  logic [NUM_LINES-1:0] clr_lines;
  logic [DATA_W-1:0]    odd_bits;
  logic                 clr_write;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_clr
    assign clr_lines[g] = reg_wr_data[g*LINE_STRIDE];
  end
  for (genvar b = 0; b < DATA_W; b++) begin : g_odd
    assign odd_bits[b] = !((b % LINE_STRIDE) == 0 && (b / LINE_STRIDE) < NUM_LINES);
  end
  assign clr_write = reg_wr_en && (reg_word_addr == WORD_IDX_W'(IDX_PLS_ST));

  assert_pulse_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (|intx_pulse) |=> ((status_q & $past(intx_pulse)) == $past(intx_pulse)));

  assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (|($past(status_q) & ~status_q)) |-> $past(clr_write));

  assert_clear_bits_R4: assert property (@(posedge clk) disable iff (rst)
    clr_write |=> ((status_q & $past(clr_lines & ~intx_pulse)) == '0));

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_write && |(clr_lines & intx_pulse))
      |=> ((status_q & $past(clr_lines & intx_pulse)) == $past(clr_lines & intx_pulse)));

  assert_irq_idle_R6: assert property (@(posedge clk) disable iff (rst)
    ((status_q & pls_en) == '0) |=> !irq);

  assert_irq_active_R6: assert property (@(posedge clk) disable iff (rst)
    (|(status_q & pls_en)) |=> irq);

  assert_pad_zero_R8: assert property (@(posedge clk) disable iff (rst)
    ((reg_rd_data & odd_bits) == '0));
endmodule

bind intx_pulse_collector intx_pulse_collector_chk #(
  .NUM_LINES  (NUM_LINES),
  .LINE_STRIDE(LINE_STRIDE),
  .DATA_W     (DATA_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .intx_pulse   (intx_pulse),
  .reg_wr_en    (reg_wr_en),
  .reg_word_addr(reg_word_addr),
  .reg_wr_data  (reg_wr_data),
  .reg_rd_data  (reg_rd_data),
  .irq          (irq),
  .status_q     (status_q),
  .pls_en       (pls_en)
);

// File: tb/intx_pulse_collector_test.sv
module intx_pulse_collector_test;
  localparam int NL = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NL-1:0] intx_pulse = '0;
  logic          reg_wr_en = 1'b0;
  logic [2:0]    reg_word_addr = '0;
  logic [DW-1:0] reg_wr_data = '0;
  logic [DW-1:0] reg_rd_data;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  intx_pulse_collector #(.NUM_LINES(NL), .LINE_STRIDE(2), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .intx_pulse(intx_pulse), .reg_wr_en(reg_wr_en),
    .reg_word_addr(reg_word_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .irq(irq)
  );

  function automatic logic [DW-1:0] spread(input logic [NL-1:0] m);
    logic [DW-1:0] w = '0;
    for (int i = 0; i < NL; i++) w[2*i] = m[i];
    return w;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int word, input logic [DW-1:0] data);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_word_addr = 3'(word); reg_wr_data = data;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wr_data = '0;
  endtask

  task automatic rd(input int word, output logic [DW-1:0] data);
    @(negedge clk);
    reg_word_addr = 3'(word);
    @(negedge clk);
    data = reg_rd_data;
  endtask

  task automatic pulse(input logic [NL-1:0] m);
    @(negedge clk);
    intx_pulse = m;
    @(negedge clk);
    intx_pulse = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 irq", {31'b0, irq}, '0);
    for (int w = 0; w < 8; w++) begin
      rd(w, v);
      check("R1 reg", v, '0);
    end

    // R2 R3 R6: every pulse pattern against every enable pattern
    for (int en = 0; en < 16; en++) begin
      wr(3, spread(4'(en)));
      for (int m = 0; m < 16; m++) begin
        wr(0, 32'hFFFF_FFFF);
        pulse(4'(m));
        @(negedge clk);                 // input already low: sticky
        rd(0, v);
        check("R2 R3 status", v, spread(4'(m)));
        check("R6 irq", {31'b0, irq}, {31'b0, |(4'(m) & 4'(en))});
      end
    end

    // R4: clear pattern sweep over the low byte, odd bits included
    wr(3, '0);
    for (int p = 0; p < 256; p++) begin
      pulse(4'hF);
      wr(0, 32'(p));
      rd(0, v);
      check("R4 clear", v, spread(4'hF) & ~32'(p) & spread(4'hF));
      wr(0, 32'hFFFF_FFFF);
    end

    // R5: set and clear in the same cycle on lines 0 and 2, clear on 1 and 3
    pulse(4'hF);
    @(negedge clk);
    intx_pulse = 4'b0101; reg_wr_en = 1'b1; reg_word_addr = 3'd0; reg_wr_data = spread(4'hF);
    @(negedge clk);
    intx_pulse = '0; reg_wr_en = 1'b0; reg_wr_data = '0;
    rd(0, v);
    check("R5 set wins", v, spread(4'b0101));
    wr(0, 32'hFFFF_FFFF);

    // R10: read in the same edge as a pulse shows the old value, next read the new
    @(negedge clk);
    reg_word_addr = 3'd0; intx_pulse = 4'b0010;
    @(negedge clk);
    intx_pulse = '0;
    check("R10 old value", reg_rd_data, '0);
    @(negedge clk);
    check("R10 new value", reg_rd_data, spread(4'b0010));
    wr(0, 32'hFFFF_FFFF);

    // R7 R8: plain storage words, padding ignored, no influence on irq
    pulse(4'hF);
    for (int w = 1; w < 6; w++) begin
      if (w != 3) wr(w, 32'hFFFF_FFFF);
    end
    for (int w = 1; w < 6; w++) begin
      rd(w, v);
      check("R7 R8 storage", v, (w == 3) ? '0 : 32'h0000_0055);
    end
    rd(0, v);
    check("R7 pulse status kept", v, 32'h0000_0055);
    check("R7 irq unaffected", {31'b0, irq}, '0);
    wr(2, 32'hAAAA_AA14);
    rd(2, v);
    check("R8 odd ignored", v, 32'h0000_0014);
    wr(3, 32'hAAAA_AAAA);
    rd(3, v);
    check("R8 enable pad", v, '0);
    check("R8 irq", {31'b0, irq}, '0);

    // R9: unmapped words
    wr(6, 32'hFFFF_FFFF);
    wr(7, 32'hFFFF_FFFF);
    rd(6, v); check("R9 word6", v, '0);
    rd(7, v); check("R9 word7", v, '0);
    rd(0, v); check("R9 status kept", v, 32'h0000_0055);
    rd(3, v); check("R9 enable kept", v, '0);
    rd(1, v); check("R9 level kept", v, 32'h0000_0055);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule